// File: doc/BRIEF.md
# Ordering-Mode Store Buffer Controller

This block sits between a processor's load/store port and its data cache. Stores are put in a small FIFO and leave for the cache one at a time, always oldest first. The way a load is handled depends on the selected memory ordering mode:
- In the strict mode a load waits until every earlier store has drained.
- In the bypass mode a load may go ahead of buffered stores to other addresses, but it waits for any store to its own address.
- In the forwarding mode a load that hits a buffered store takes the youngest matching value straight from the buffer.

Fence and atomic swap requests always empty the buffer before they complete. The atomic swap then performs a read and a write as two back-to-back cache accesses.

The controller handles one load, fence or swap at a time, and stores stream in between them. Every load, fence and swap produces exactly one response, in request order. A flag on each response tells whether the data came from the buffer or from the cache.

Top module: `sbuf_order_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 for a load request, `rsp_valid` is 0 and `cache_valid` is 0.
- R2: Stores reach the cache as writes (`cache_we`=1) in program order in every mode, each with the address and data given at request time. The swap's write follows the same rule.
- R3: When DEPTH stores are buffered, `req_ready` is 0 for a store request until an entry drains.
- R4: In strict mode (`mode_sel` 0, or the unused code 3), a load does not respond while any earlier store is still buffered.
- R5: In bypass mode (`mode_sel` 1), a load whose address matches no buffered store responds from the cache with `rsp_fwd`=0 while earlier stores are still stalled.
- R6: In bypass mode, a load whose address matches a buffered store does not respond until that store has been written to the cache. It then returns the stored value with `rsp_fwd`=0.
- R7: In forwarding mode (`mode_sel` 2), a load that matches buffered stores returns the data of the youngest match with `rsp_fwd`=1 while those stores are still stalled. A load that matches no buffered store goes to the cache.
- R8: A fence responds (`rsp_valid`=1, `rsp_data`=0, `rsp_fwd`=0) only once the buffer is empty. No request is accepted before that response.
- R9: A swap (op 3) waits for the buffer to empty, then issues a cache read and, as the very next cache access, a write of its new data to the same address. It responds with the old value and `rsp_fwd`=0.
- R10: `mode_sel` is taken only while the controller is idle with an empty buffer. A change made while stores are pending affects only loads issued after the drain.
- R11: Request op codes are: 0 load, 1 store, 2 fence, 3 swap. Exactly one response is produced for each load, fence and swap, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Ordering mode: 0 strict, 1 bypass, 2 forwarding, 3 treated as strict |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_op | input | 2 | 0 load, 1 store, 2 fence, 3 swap |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data or swap new value |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | DW | Load data, swap old value, or 0 for a fence |
| rsp_fwd | output | 1 | 1 when the data came from the buffer |
| cache_valid | output | 1 | Cache access request |
| cache_ready | input | 1 | Cache accepts the access this cycle |
| cache_we | output | 1 | 1 write, 0 read |
| cache_addr | output | AW | Access address |
| cache_wdata | output | DW | Write data |
| cache_rvalid | input | 1 | Read data returned |
| cache_rdata | input | DW | Read data |

## Verification
The bench builds the block with DEPTH=4, AW=4 and DW=16. With these values the full-buffer limit is reached after four stores, and a sixteen-word cache model can be mirrored by a program-order reference. The cache model refuses writes while a hold flag is set but keeps serving reads. This freezes buffered stores in place, so the bench can tell whether a load is stalled, bypasses the stores or is forwarded. The same hold makes fence and swap drain timing deterministic, and it is what exposes the deferred mode switch.

// File: rtl/sbuf_pkg.sv
`timescale 1ns/1ps
package sbuf_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FENCE = 2'd2,
    OP_SWAP  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    MD_STRICT = 2'd0,
    MD_BYPASS = 2'd1,
    MD_FWD    = 2'd2,
    MD_SPARE  = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LD_WAIT,
    ST_FENCE,
    ST_SW_DRAIN,
    ST_SW_RD,
    ST_SW_WAIT,
    ST_SW_WR
  } state_e;

endpackage

// File: rtl/sbuf_fifo.sv
`timescale 1ns/1ps
module sbuf_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic [DW-1:0] lk_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_mem [DEPTH];
  logic [DW-1:0] data_mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  // entry storage, no reset on the payload
  always_ff @(posedge clk) begin
    if (push) begin
      addr_mem[wr_ptr] <= push_addr;
      data_mem[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));
  assign head_addr = addr_mem[rd_ptr];
  assign head_data = data_mem[rd_ptr];

  // scan oldest to youngest, a later hit overrides an earlier one
  always_comb begin
    lk_hit  = 1'b0;
    lk_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PW:0] ix;
      ix = {1'b0, rd_ptr} + (PW+1)'(k);
      if (ix >= (PW+1)'(DEPTH)) ix = ix - (PW+1)'(DEPTH);
      if ((CW'(k) < count) && (addr_mem[ix[PW-1:0]] == lk_addr)) begin
        lk_hit  = 1'b1;
        lk_data = data_mem[ix[PW-1:0]];
      end
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

endmodule

// File: rtl/sbuf_ctrl.sv
`timescale 1ns/1ps
module sbuf_ctrl
  import sbuf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode_sel,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_fwd,
  output logic          cache_valid,
  input  logic          cache_ready,
  output logic          cache_we,
  output logic [AW-1:0] cache_addr,
  output logic [DW-1:0] cache_wdata,
  input  logic          cache_rvalid,
  input  logic [DW-1:0] cache_rdata,
  output logic          f_push,
  output logic          f_pop,
  input  logic          f_empty,
  input  logic          f_full,
  input  logic [AW-1:0] f_head_addr,
  input  logic [DW-1:0] f_head_data,
  output logic [AW-1:0] f_lk_addr,
  input  logic          f_lk_hit,
  input  logic [DW-1:0] f_lk_data
);
  state_e        state;
  mode_e         mode_q;
  op_e           op;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_wdata;
  logic [DW-1:0] p_old;
  logic          accept;
  logic          ld_to_cache, ld_forward;
  logic          rd_issue, sw_write, drain_ok;

  assign op        = op_e'(req_op);
  assign req_ready = (state == ST_IDLE) && !((op == OP_STORE) && f_full);
  assign accept    = req_valid && req_ready;
  assign f_push    = accept && (op == OP_STORE);
  assign f_lk_addr = p_addr;

  // load policy per ordering mode
  always_comb begin
    ld_forward = 1'b0;
    case (mode_q)
      MD_BYPASS: ld_to_cache = !f_lk_hit;
      MD_FWD: begin
        ld_to_cache = !f_lk_hit;
        ld_forward  = f_lk_hit;
      end
      default:   ld_to_cache = f_empty;
    endcase
  end

  // cache port arbitration: pending read/swap write first, then drain
  assign rd_issue = ((state == ST_LOAD) && ld_to_cache) || (state == ST_SW_RD);
  assign sw_write = (state == ST_SW_WR);
  always_comb begin
    case (state)
      ST_IDLE, ST_FENCE, ST_SW_DRAIN: drain_ok = !f_empty;
      ST_LOAD:                        drain_ok = !f_empty && !ld_to_cache;
      default:                        drain_ok = 1'b0;
    endcase
  end

  assign cache_valid = rd_issue || sw_write || drain_ok;
  assign cache_we    = !rd_issue;
  assign cache_addr  = (rd_issue || sw_write) ? p_addr : f_head_addr;
  assign cache_wdata = sw_write ? p_wdata : f_head_data;
  assign f_pop       = drain_ok && cache_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mode_q    <= MD_STRICT;
      p_addr    <= '0;
      p_wdata   <= '0;
      p_old     <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_fwd   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if ((state == ST_IDLE) && f_empty) mode_q <= mode_e'(mode_sel);
      case (state)
        ST_IDLE: begin
          if (accept) begin
            p_addr  <= req_addr;
            p_wdata <= req_wdata;
            case (op)
              OP_LOAD:  state <= ST_LOAD;
              OP_FENCE: state <= ST_FENCE;
              OP_SWAP:  state <= ST_SW_DRAIN;
              default:  state <= ST_IDLE;
            endcase
          end
        end
        ST_LOAD: begin
          if (ld_forward) begin
            rsp_valid <= 1'b1;
            rsp_data  <= f_lk_data;
            rsp_fwd   <= 1'b1;
            state     <= ST_IDLE;
          end else if (ld_to_cache && cache_ready) begin
            state <= ST_LD_WAIT;
          end
        end
        ST_LD_WAIT: begin
          if (cache_rvalid) begin
            rsp_valid <= 1'b1;
            rsp_data  <= cache_rdata;
            rsp_fwd   <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        ST_FENCE: begin
          if (f_empty) begin
            rsp_valid <= 1'b1;
            rsp_data  <= '0;
            rsp_fwd   <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        ST_SW_DRAIN: if (f_empty) state <= ST_SW_RD;
        ST_SW_RD:    if (cache_ready) state <= ST_SW_WAIT;
        ST_SW_WAIT: begin
          if (cache_rvalid) begin
            p_old <= cache_rdata;
            state <= ST_SW_WR;
          end
        end
        ST_SW_WR: begin
          if (cache_ready) begin
            rsp_valid <= 1'b1;
            rsp_data  <= p_old;
            rsp_fwd   <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_strict_load_R4: assert property (@(posedge clk) disable iff (rst)
    (cache_valid && !cache_we && (state == ST_LOAD) && (mode_q == MD_STRICT)) |-> f_empty);

  assert_fwd_mode_only_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fwd) |-> (mode_q == MD_FWD));

  assert_fence_waits_R8: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_FENCE) && !f_empty) |=> !rsp_valid);

  assert_swap_gap_R9: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_SW_RD) && cache_ready) |=> !cache_valid);

  assert_swap_write_R9: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_SW_WAIT) && cache_rvalid) |=> (cache_valid && cache_we && (cache_addr == $past(p_addr))));

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !f_empty |=> $stable(mode_q));

endmodule

// File: rtl/sbuf_order_ctrl.sv
`timescale 1ns/1ps
module sbuf_order_ctrl #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode_sel,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_fwd,
  output logic          cache_valid,
  input  logic          cache_ready,
  output logic          cache_we,
  output logic [AW-1:0] cache_addr,
  output logic [DW-1:0] cache_wdata,
  input  logic          cache_rvalid,
  input  logic [DW-1:0] cache_rdata
);
  logic          f_push, f_pop, f_empty, f_full, f_lk_hit;
  logic [AW-1:0] f_head_addr, f_lk_addr;
  logic [DW-1:0] f_head_data, f_lk_data;

  sbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (f_push),
    .push_addr (req_addr),
    .push_data (req_wdata),
    .pop       (f_pop),
    .head_addr (f_head_addr),
    .head_data (f_head_data),
    .empty     (f_empty),
    .full      (f_full),
    .lk_addr   (f_lk_addr),
    .lk_hit    (f_lk_hit),
    .lk_data   (f_lk_data)
  );

  sbuf_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .mode_sel     (mode_sel),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_op       (req_op),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .rsp_fwd      (rsp_fwd),
    .cache_valid  (cache_valid),
    .cache_ready  (cache_ready),
    .cache_we     (cache_we),
    .cache_addr   (cache_addr),
    .cache_wdata  (cache_wdata),
    .cache_rvalid (cache_rvalid),
    .cache_rdata  (cache_rdata),
    .f_push       (f_push),
    .f_pop        (f_pop),
    .f_empty      (f_empty),
    .f_full       (f_full),
    .f_head_addr  (f_head_addr),
    .f_head_data  (f_head_data),
    .f_lk_addr    (f_lk_addr),
    .f_lk_hit     (f_lk_hit),
    .f_lk_data    (f_lk_data)
  );

endmodule

// File: tb/sbuf_order_ctrl_bench.sv
`timescale 1ns/1ps
module sbuf_order_ctrl_bench;
  localparam int DEPTH = 4;
  localparam int AW    = 4;
  localparam int DW    = 16;
  localparam int NW    = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    mode_sel;
  logic          req_valid;
  logic          req_ready;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          rsp_fwd;
  logic          cache_valid, cache_ready, cache_we, cache_rvalid;
  logic [AW-1:0] cache_addr;
  logic [DW-1:0] cache_wdata, cache_rdata;
  logic          hold_wr;

  always #2 clk = ~clk;

  sbuf_order_ctrl #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_sbuf_order_ctrl (
    .clk(clk), .rst(rst), .mode_sel(mode_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fwd(rsp_fwd),
    .cache_valid(cache_valid), .cache_ready(cache_ready), .cache_we(cache_we),
    .cache_addr(cache_addr), .cache_wdata(cache_wdata),
    .cache_rvalid(cache_rvalid), .cache_rdata(cache_rdata)
  );

  // cache model: refuses writes while hold_wr, reads answer next cycle
  logic [DW-1:0] cmem [NW];
  assign cache_ready = !(hold_wr && cache_we);
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) cmem[i] <= DW'(16'h100 + i);
      cache_rvalid <= 1'b0;
      cache_rdata  <= '0;
    end else begin
      cache_rvalid <= 1'b0;
      if (cache_valid && cache_ready) begin
        if (cache_we) cmem[cache_addr] <= cache_wdata;
        else begin
          cache_rvalid <= 1'b1;
          cache_rdata  <= cmem[cache_addr];
        end
      end
    end
  end

  // program-order reference and scoreboards
  logic [DW-1:0]    ref_mem [NW];
  logic [DW:0]      exp_q [$];
  logic [AW+DW-1:0] wr_q [$];
  int checks = 0;
  int errs   = 0;
  int rsp_cnt = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: responses (R11 order) and cache writes (R2 order)
  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid) begin
        rsp_cnt++;
        if (exp_q.size() == 0) chk(1'b0, "R11 unexpected response", {15'd0, rsp_fwd, rsp_data}, 32'd0);
        else begin
          logic [DW:0] e;
          e = exp_q.pop_front();
          chk({rsp_fwd, rsp_data} == e, "R11 response fwd/data", {15'd0, rsp_fwd, rsp_data}, {15'd0, e});
        end
      end
      if (cache_valid && cache_ready && cache_we) begin
        if (wr_q.size() == 0) chk(1'b0, "R2 unexpected write", {12'd0, cache_addr, cache_wdata}, 32'd0);
        else begin
          logic [AW+DW-1:0] w;
          w = wr_q.pop_front();
          chk({cache_addr, cache_wdata} == w, "R2 write order", {12'd0, cache_addr, cache_wdata}, {12'd0, w});
        end
      end
    end
  end

  // driver: presents one request, records expectations on acceptance
  task automatic send(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit efwd);
    @(posedge clk); #1;
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    case (op)
      2'd0: exp_q.push_back({efwd, ref_mem[a]});
      2'd1: begin wr_q.push_back({a, d}); ref_mem[a] = d; end
      2'd2: exp_q.push_back({1'b0, {DW{1'b0}}});
      default: begin
        exp_q.push_back({1'b0, ref_mem[a]});
        wr_q.push_back({a, d});
        ref_mem[a] = d;
      end
    endcase
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 300; i++) begin
      @(posedge clk);
      if (exp_q.size() == 0 && wr_q.size() == 0) break;
    end
    repeat (3) @(posedge clk);
    chk(exp_q.size() == 0 && wr_q.size() == 0, "R11 drain complete", exp_q.size() + wr_q.size(), 0);
  endtask

  task automatic wait_cycles_rsp(input int n, output int seen);
    int base;
    base = rsp_cnt;
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
    seen = rsp_cnt - base;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    int seen;
    for (int i = 0; i < NW; i++) ref_mem[i] = DW'(16'h100 + i);
    rst = 1'b1; mode_sel = 2'd0; req_valid = 1'b0; req_op = 2'd0;
    req_addr = '0; req_wdata = '0; hold_wr = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 req_ready after reset", 32'(req_ready), 1);
    chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 0);
    chk(cache_valid === 1'b0, "R1 cache_valid after reset", 32'(cache_valid), 0);

    // R4: strict mode, unrelated load still waits for stores
    hold_wr = 1'b1;
    send(2'd1, 4'd3, 16'h00A1, 1'b0);
    send(2'd1, 4'd5, 16'h00B2, 1'b0);
    send(2'd0, 4'd7, '0, 1'b0);
    wait_cycles_rsp(10, seen);
    chk(seen == 0, "R4 strict load held behind stores", seen, 0);
    hold_wr = 1'b0;
    settle();

    // R3: full buffer blocks further stores
    hold_wr = 1'b1;
    for (int i = 0; i < DEPTH; i++) send(2'd1, AW'(i), DW'(16'h0C00 + i), 1'b0);
    @(posedge clk); #1;
    req_valid = 1'b1; req_op = 2'd1; req_addr = 4'd9; req_wdata = 16'h0CCC;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0, "R3 ready low when full", 32'(req_ready), 0);
    req_valid = 1'b0;
    hold_wr = 1'b0;
    settle();

    // R5/R6: bypass mode
    mode_sel = 2'd1;
    repeat (3) @(posedge clk);
    hold_wr = 1'b1;
    send(2'd1, 4'd2, 16'h0D22, 1'b0);
    send(2'd0, 4'd9, '0, 1'b0);
    wait_cycles_rsp(10, seen);
    chk(seen == 1, "R5 unrelated load bypasses stalled store", seen, 1);
    send(2'd0, 4'd2, '0, 1'b0);
    wait_cycles_rsp(10, seen);
    chk(seen == 0, "R6 matching load waits for drain", seen, 0);
    hold_wr = 1'b0;
    settle();

    // R7: forwarding mode
    mode_sel = 2'd2;
    repeat (3) @(posedge clk);
    hold_wr = 1'b1;
    send(2'd1, 4'd4, 16'h0E41, 1'b0);
    send(2'd1, 4'd4, 16'h0E42, 1'b0);
    send(2'd1, 4'd6, 16'h0E61, 1'b0);
    send(2'd0, 4'd4, '0, 1'b1);
    wait_cycles_rsp(10, seen);
    chk(seen == 1, "R7 forwarded youngest store while stalled", seen, 1);
    send(2'd0, 4'd8, '0, 1'b0);
    wait_cycles_rsp(10, seen);
    chk(seen == 1, "R7 unmatched load served by cache", seen, 1);
    hold_wr = 1'b0;
    settle();

    // R8: fence
    hold_wr = 1'b1;
    send(2'd1, 4'd1, 16'h0F11, 1'b0);
    send(2'd2, '0, '0, 1'b0);
    wait_cycles_rsp(10, seen);
    chk(seen == 0, "R8 fence not acked with store pending", seen, 0);
    req_op = 2'd0;
    #1;
    chk(req_ready == 1'b0, "R8 no request accepted during fence", 32'(req_ready), 0);
    hold_wr = 1'b0;
    settle();

    // R10: mode change deferred while stores pending
    hold_wr = 1'b1;
    send(2'd1, 4'd10, 16'h0A10, 1'b0);
    mode_sel = 2'd0;
    send(2'd0, 4'd10, '0, 1'b1);
    wait_cycles_rsp(10, seen);
    chk(seen == 1, "R10 old forwarding mode kept while pending", seen, 1);
    hold_wr = 1'b0;
    settle();
    hold_wr = 1'b1;
    send(2'd1, 4'd11, 16'h0B11, 1'b0);
    send(2'd0, 4'd12, '0, 1'b0);
    wait_cycles_rsp(10, seen);
    chk(seen == 0, "R10 strict mode active after drain", seen, 0);
    hold_wr = 1'b0;
    settle();

    // R9: swap after a buffered store
    hold_wr = 1'b1;
    send(2'd1, 4'd13, 16'h0613, 1'b0);
    send(2'd3, 4'd13, 16'h0713, 1'b0);
    wait_cycles_rsp(8, seen);
    chk(seen == 0, "R9 swap waits for buffer drain", seen, 0);
    hold_wr = 1'b0;
    settle();
    send(2'd0, 4'd13, '0, 1'b0);
    settle();
    chk(cmem[13] == 16'h0713, "R9 swap new value in cache", 32'(cmem[13]), 32'h0713);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule